// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block takes a requested clock output frequency in kHz and works out the three divider settings of a fractional-free PLL: the input (reference) divider, the feedback multiplier and the post divider. The reference frequency is fixed at build time as a parameter. The engine first picks the smallest legal post divider, which fixes the VCO frequency. It then sweeps the input divider upward. For each candidate it rounds the feedback divider to the nearest integer and keeps the candidate whose VCO error is smallest.

All integer divisions go through one shared restoring divider that produces one quotient bit per clock. A search therefore takes from a few hundred to a few thousand cycles. A controller pulses `start` with the target held on `target_khz`, waits for `done`, and then reads either the three divisor values or the `error` flag. Writing the values into the PLL is left to the surrounding logic.

Top module: `pll_div_search`

## Requirements
- R1: A start with `target_khz` equal to zero returns no search. One clock after the start, `done` and `error` are both high for exactly one cycle.
- R2: The post divider is ceil(VCO_MIN / target), with VCO_MIN = 440000 kHz. A result above 1 is raised to the next even value. A post divider of 16 or more ends the request with `error`.
- R3: The VCO frequency is target times the post divider. If it lies below 440000 kHz or above 2200000 kHz, the request ends with `error`.
- R4: The input divider steps 1, 2, 3 ... while it stays below 64, and each step divides the reference by it with truncation. The sweep stops as soon as this quotient is below 269 kHz. A step whose quotient exceeds 2200000 kHz is skipped.
- R5: The feedback divider is VCO / fref, truncated, and a result of 4096 or more skips the step. If the remainder is strictly greater than fref/2 (truncated) and the divider plus one is below 4096, the divider is incremented. In that case the error becomes fref minus the remainder; otherwise the error is the remainder.
- R6: A candidate replaces the stored best only when its error is strictly smaller, so on a tie the smaller input divider wins. The sweep ends at the first candidate with zero error.
- R7: The best error starts equal to the VCO value. If it is still above 4000 kHz when the sweep ends, the request ends with `error`.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` rises. A start seen while busy is ignored and produces no later result.
- R9: On success, `nr`, `nf` and `no` are updated in the cycle `done` is high. On any error, all three keep their previous values.
- R10: `nr`, `nf` and `no` carry the actual divisor values, not the values minus one. The post divider is always 1 or even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when not busy |
| target_khz | input | TW | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High with `done` when no valid setting was found |
| nr | output | 6 | Chosen input divider |
| nf | output | 12 | Chosen feedback divider |
| no | output | 4 | Chosen post divider |

## Verification
The bench builds two instances. The first uses the default 24000 kHz reference. With it, exact hits at several input dividers and ties between dividers can be reached, along with rounding both up and down, post-divider and VCO-range failures, and a long sweep compared against a bench-side model over many targets. The second uses a 200 kHz reference, so the first input divider already falls below the 269 kHz floor. That forces the early stop and brings the 4000 kHz tolerance failure within reach, which a 24000 kHz reference can never produce.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WNO,
    ST_SETUP,
    ST_WREF,
    ST_WNF,
    ST_EVAL,
    ST_NEXT,
    ST_END
  } srch_st_t;
endpackage

// File: rtl/pll_rdiv.sv
module pll_rdiv #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, q_sh, den_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;
  logic          ge;

  assign trial = {acc, q_sh[W-1]};
  assign ge    = trial >= {1'b0, den_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; q_sh <= '0; den_r <= '0; cnt <= '0; run <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc   <= '0;
        q_sh  <= num;
        den_r <= den;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        acc  <= ge ? W'(trial - {1'b0, den_r}) : trial[W-1:0];
        q_sh <= {q_sh[W-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = q_sh;
  assign rem = acc;
endmodule

// File: rtl/pll_nf_round.sv
module pll_nf_round #(
  parameter int W      = 28,
  parameter int NF_LIM = 4096
) (
  input  logic [W-1:0] q,
  input  logic [W-1:0] r,
  input  logic [W-1:0] fref,
  output logic [W-1:0] nf_c,
  output logic [W-1:0] diff_c,
  output logic         ok
);
  localparam logic [W-1:0] LIM = W'(NF_LIM);
  logic up;

  always_comb begin
    ok     = q < LIM;
    up     = ((q + 1'b1) < LIM) && (r > (fref >> 1));
    nf_c   = up ? q + 1'b1 : q;
    diff_c = up ? fref - r : r;
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int TW           = 24,
  parameter int REF_KHZ      = 24000,
  parameter int VCO_MIN_KHZ  = 440000,
  parameter int VCO_MAX_KHZ  = 2200000,
  parameter int FREF_MIN_KHZ = 269,
  parameter int FREF_MAX_KHZ = 2200000,
  parameter int TOL_KHZ      = 4000,
  parameter int NR_LIM       = 64,
  parameter int NF_LIM       = 4096,
  parameter int NO_LIM       = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [TW-1:0]             target_khz,
  output logic                      busy,
  output logic                      done,
  output logic                      error,
  output logic [$clog2(NR_LIM)-1:0] nr,
  output logic [$clog2(NF_LIM)-1:0] nf,
  output logic [$clog2(NO_LIM)-1:0] no
);
  import pll_div_pkg::*;

  localparam int NR_W = $clog2(NR_LIM);
  localparam int NF_W = $clog2(NF_LIM);
  localparam int NO_W = $clog2(NO_LIM);
  localparam int DW   = TW + NO_W;
  localparam logic [DW-1:0] K_VMIN = DW'(VCO_MIN_KHZ);
  localparam logic [DW-1:0] K_VMAX = DW'(VCO_MAX_KHZ);
  localparam logic [DW-1:0] K_FMIN = DW'(FREF_MIN_KHZ);
  localparam logic [DW-1:0] K_FMAX = DW'(FREF_MAX_KHZ);
  localparam logic [DW-1:0] K_TOL  = DW'(TOL_KHZ);
  localparam logic [DW-1:0] K_REF  = DW'(REF_KHZ);
  localparam logic [DW-1:0] K_NOL  = DW'(NO_LIM);
  localparam logic [NR_W:0] K_NRL  = (NR_W+1)'(NR_LIM);

  srch_st_t      st;
  logic [DW-1:0] tgt, no_r, vco, best, fref, nq, nr_rem;
  logic [NR_W:0] nr_cur;
  logic [NR_W-1:0] bnr;
  logic [NF_W-1:0] bnf;
  logic          fail;

  logic          dgo, dfin;
  logic [DW-1:0] dnum, dden, dq, dr;
  logic [DW-1:0] no_c, vco_c, nf_c, diff_c;
  logic          nf_ok;

  pll_rdiv #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .go(dgo), .num(dnum), .den(dden),
    .quo(dq), .rem(dr), .fin(dfin)
  );

  pll_nf_round #(.W(DW), .NF_LIM(NF_LIM)) u_round (
    .q(nq), .r(nr_rem), .fref(fref), .nf_c(nf_c), .diff_c(diff_c), .ok(nf_ok)
  );

  always_comb begin
    no_c = dq + DW'(dr != '0);
    if (no_c > DW'(1) && no_c[0]) no_c = no_c + 1'b1;
    vco_c = tgt * no_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy <= 1'b0; done <= 1'b0; error <= 1'b0;
      nr <= '0; nf <= '0; no <= '0;
      tgt <= '0; no_r <= '0; vco <= '0; best <= '0; fref <= '0;
      nq <= '0; nr_rem <= '0; nr_cur <= '0; bnr <= '0; bnf <= '0;
      fail <= 1'b0; dgo <= 1'b0; dnum <= '0; dden <= '0;
    end else begin
      dgo   <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (target_khz == '0) begin
            done  <= 1'b1;
            error <= 1'b1;
          end else begin
            tgt  <= DW'(target_khz);
            dnum <= K_VMIN;
            dden <= DW'(target_khz);
            dgo  <= 1'b1;
            busy <= 1'b1;
            fail <= 1'b0;
            st   <= ST_WNO;
          end
        end
        ST_WNO: if (dfin) begin
          no_r <= no_c;
          st   <= ST_SETUP;
        end
        ST_SETUP: begin
          vco  <= vco_c;
          best <= vco_c;
          if (no_r >= K_NOL || vco_c < K_VMIN || vco_c > K_VMAX) begin
            fail <= 1'b1;
            st   <= ST_END;
          end else begin
            nr_cur <= (NR_W+1)'(1);
            dnum   <= K_REF;
            dden   <= DW'(1);
            dgo    <= 1'b1;
            st     <= ST_WREF;
          end
        end
        ST_WREF: if (dfin) begin
          fref <= dq;
          if (dq < K_FMIN) st <= ST_END;
          else if (dq > K_FMAX) st <= ST_NEXT;
          else begin
            dnum <= vco;
            dden <= dq;
            dgo  <= 1'b1;
            st   <= ST_WNF;
          end
        end
        ST_WNF: if (dfin) begin
          nq     <= dq;
          nr_rem <= dr;
          st     <= ST_EVAL;
        end
        ST_EVAL: begin
          if (nf_ok && diff_c < best) begin
            best <= diff_c;
            bnr  <= nr_cur[NR_W-1:0];
            bnf  <= nf_c[NF_W-1:0];
          end
          st <= ST_NEXT;
        end
        ST_NEXT: begin
          if ((nr_cur + 1'b1) < K_NRL && best != '0) begin
            nr_cur <= nr_cur + 1'b1;
            dnum   <= K_REF;
            dden   <= DW'(nr_cur + 1'b1);
            dgo    <= 1'b1;
            st     <= ST_WREF;
          end else begin
            st <= ST_END;
          end
        end
        ST_END: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
          if (fail || best > K_TOL) begin
            error <= 1'b1;
          end else begin
            nr <= bnr;
            nf <= bnf;
            no <= no_r[NO_W-1:0];
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int NR_W = 6,
  parameter int NF_W = 12,
  parameter int NO_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            error,
  input logic [NR_W-1:0] nr,
  input logic [NF_W-1:0] nf,
  input logic [NO_W-1:0] no
);
  // R1: completion pulse lasts a single cycle
  a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1: error never appears without done
  a_r1_err_with_done: assert property (@(posedge clk) disable iff (rst)
    error |-> done);
  // R8: busy has dropped when done is raised
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: outputs change only on a successful completion
  a_r9_hold_nr: assert property (@(posedge clk) disable iff (rst)
    !(done && !error) |-> ($stable(nr) && $stable(nf) && $stable(no)));
  // R10: post divider is one or even after success
  a_r10_no_even: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (no == NO_W'(1) || !no[0]));
endmodule

bind pll_div_search pll_div_search_chk #(
  .NR_W($clog2(NR_LIM)), .NF_W($clog2(NF_LIM)), .NO_W($clog2(NO_LIM))
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .error(error),
  .nr(nr), .nf(nf), .no(no)
);

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        start, start_lo;
  logic [23:0] tgt, tgt_lo;
  logic        busy, done, error, busy_lo, done_lo, error_lo;
  logic [5:0]  nr, nr_lo;
  logic [11:0] nf, nf_lo;
  logic [3:0]  no, no_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  pll_div_search dut (
    .clk(clk), .rst(rst), .start(start), .target_khz(tgt),
    .busy(busy), .done(done), .error(error), .nr(nr), .nf(nf), .no(no)
  );

  pll_div_search #(.REF_KHZ(200)) dut_lo (
    .clk(clk), .rst(rst), .start(start_lo), .target_khz(tgt_lo),
    .busy(busy_lo), .done(done_lo), .error(error_lo), .nr(nr_lo), .nf(nf_lo), .no(no_lo)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint t, input longint rf, output bit err,
                                output longint enr, output longint enf, output longint eno);
    longint nov, vco, best, fr, q, d;
    err = 0; enr = 0; enf = 0; eno = 0;
    if (t == 0) begin err = 1; return; end
    nov = (440000 + t - 1) / t;
    if (nov > 1) nov = ((nov + 1) / 2) * 2;
    vco = t * nov;
    if (nov >= 16 || vco < 440000 || vco > 2200000) begin err = 1; return; end
    eno = nov;
    best = vco;
    for (longint k = 1; k < 64 && best != 0; k++) begin
      fr = rf / k;
      if (fr < 269) break;
      if (fr > 2200000) continue;
      q = vco / fr;
      if (q >= 4096) continue;
      d = vco - q * fr;
      if (q + 1 < 4096 && d > fr / 2) begin q++; d = fr - d; end
      if (d < best) begin best = d; enr = k; enf = q; end
    end
    if (best > 4000) err = 1;
  endfunction

  // run one request on the main instance; returns at the negedge where done is high
  task automatic run(input logic [23:0] t, output bit got);
    int w = 0;
    got = 0;
    @(negedge clk); tgt = t; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    got = done;
    chk(got, "R8 completion", w, 0);
  endtask

  task automatic expect_ok(input logic [23:0] t, input longint enr, input longint enf,
                           input longint eno, input string req);
    bit g;
    run(t, g);
    chk(g && !error, req, error, 0);
    chk(nr == enr && nf == enf && no == eno, req, {nr, nf, no}, (enr << 16) | (enf << 4) | eno);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !error, "R8 reset flags", {busy, done, error}, 0);
    chk(nr == 0 && nf == 0 && no == 0, "R9 reset outputs", {nr, nf, no}, 0);
  endtask

  task automatic t_zero;
    @(negedge clk); tgt = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done && error, "R1 zero target", {done, error}, 3);
    @(negedge clk);
    chk(!done && !error, "R1 single pulse", {done, error}, 0);
  endtask

  task automatic t_known;
    expect_ok(24'd148500, 4, 99, 4, "R6 exact hit after ties");
    expect_ok(24'd100000, 1, 25, 6, "R2 even post divider");
    expect_ok(24'd440000, 3, 55, 1, "R5 rounding up at nr2");
    expect_ok(24'd2200000, 3, 275, 1, "R10 top of range");
  endtask

  task automatic t_keep_on_error;
    bit g;
    logic [5:0] pnr; logic [11:0] pnf; logic [3:0] pno;
    pnr = nr; pnf = nf; pno = no;
    run(24'd3000000, g);
    chk(error, "R3 vco above range", error, 1);
    chk(nr == pnr && nf == pnf && no == pno, "R9 hold on error", {nr, nf, no}, {pnr, pnf, pno});
    run(24'd20, g);
    chk(error, "R2 post divider limit", error, 1);
    chk(nr == pnr && nf == pnf && no == pno, "R9 hold after no fail", {nr, nf, no}, {pnr, pnf, pno});
  endtask

  task automatic t_busy_ignore;
    int extra = 0;
    @(negedge clk); tgt = 24'd148500; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy, "R8 busy during search", busy, 1);
    tgt = 24'd100000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk(nr == 4 && nf == 99 && no == 4, "R8 first request kept", {nr, nf, no}, (4 << 16) | (99 << 4) | 4);
    repeat (400) begin @(negedge clk); if (done || busy) extra++; end
    chk(extra == 0, "R8 ignored start", extra, 0);
  endtask

  task automatic t_model;
    longint ts[12] = '{27000, 54000, 74250, 65000, 33333, 123457, 297000, 500001,
                       999999, 1234567, 1800000, 2199999};
    foreach (ts[i]) begin
      bit e, g; longint a, b, c;
      model(ts[i], 24000, e, a, b, c);
      run(24'(ts[i]), g);
      chk(error == e, "R7 model error flag", error, e);
      if (!e) chk(nr == a && nf == b && no == c, "R5 model divisors", {nr, nf, no},
                  (a << 16) | (b << 4) | c);
    end
  endtask

  task automatic t_lo_ref;
    int w = 0;
    @(negedge clk); tgt_lo = 24'd150000; start_lo = 1'b1;
    @(negedge clk); start_lo = 1'b0;
    while (!done_lo && w < 5000) begin @(negedge clk); w++; end
    chk(done_lo && error_lo, "R4 early stop then R7 tolerance", {done_lo, error_lo}, 3);
    chk(w < 200, "R4 sweep stopped at first divider", w, 200);
    chk(nr_lo == 0 && nf_lo == 0 && no_lo == 0, "R9 lo outputs held", {nr_lo, nf_lo, no_lo}, 0);
  endtask

  initial begin
    start = 0; start_lo = 0; tgt = 0; tgt_lo = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_zero;
    t_known;
    t_keep_on_error;
    t_busy_ignore;
    t_model;
    t_lo_ref;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule